// File: doc/BRIEF.md
# Vector Immediate Broadcast Unit

This block executes an unpredicated vector operation that fills a whole destination vector with one small signed constant. The request carries a 2-bit element-size code, a shift flag, an 8-bit two's-complement immediate and a 5-bit destination register number. The unit sign-extends the immediate and multiplies it by 256 when the shift flag is set. It keeps only as many low bits as one element holds and copies that element pattern into every element position of a vector whose width is a parameter.

One combination is not a legal encoding: byte elements with the shift flag set. For that combination the unit raises an illegal flag instead of a write enable, and it drives a zero vector. The destination number is still reported. All outputs are registered, and a request always takes exactly one clock cycle, whatever its operand values.

Top module: `vimm_bcast`

## Requirements
- R1: The size code selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R2: The immediate is read as a signed value from -128 to +127 and is sign-extended to the element width.
- R3: With the shift flag at 1, the sign-extended immediate is shifted left by 8 bits (multiplied by 256) before it is truncated to the element width.
- R4: Size code 2'b00 with shift flag 1 is illegal: one cycle later `out_illegal` is 1 and `out_we` is 0.
- R5: On a legal request, every element of `out_data` (element k occupying bits k*W to k*W+W-1) holds the same low W bits of the scaled immediate.
- R6: Outputs appear exactly one cycle after the clock edge that samples `in_valid` high. `out_we` is high for one cycle per legal request, and neither `out_we` nor `out_illegal` is high in a cycle that follows an edge with `in_valid` low.
- R7: `out_dst` reports the register number of the last accepted request, for legal and illegal requests alike.
- R8: For an illegal request, `out_data` is all zeros.
- R9: A synchronous active-high `rst` clears `out_we`, `out_illegal`, `out_data` and `out_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Element-size code |
| in_shift | input | 1 | Shift-by-8 flag |
| in_imm | input | 8 | Signed immediate |
| in_dst | input | 5 | Destination register number |
| out_data | output | VLEN | Broadcast vector result |
| out_we | output | 1 | Register write enable, one pulse per legal request |
| out_dst | output | 5 | Destination register number of the last request |
| out_illegal | output | 1 | Illegal-encoding flag |

## Verification
The bench sweeps every immediate value with every size code and both shift settings. The negative immediates show that the sign bit reaches all bits of the wider elements. The shifted cases show whether the low byte is zero and whether the shift is truncated correctly at 16-bit elements. The byte-with-shift column separates the illegal path, with its zero data and withheld write, from the legal ones. An idle cycle after each request checks that the enable does not linger, and the destination number changes on every request so that a stale or swapped index is caught.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int IMM_W  = 8;
    localparam int REG_W  = 5;
    localparam int LANE_W = 64;
    localparam int SCL_W  = IMM_W + 8;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } esize_e;

    typedef struct packed {
        esize_e           size;
        logic             shift;
        logic [IMM_W-1:0] imm;
    } bcast_req_t;

    // Sign-extend the immediate to 16 bits and apply the optional x256 scaling.
    function automatic logic [SCL_W-1:0] scale_imm(input logic [IMM_W-1:0] imm,
                                                   input logic shift);
        logic [SCL_W-1:0] ext;
        ext = {{(SCL_W-IMM_W){imm[IMM_W-1]}}, imm};
        return shift ? (ext << 8) : ext;
    endfunction

endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
    import vbc_pkg::*;
(
    input  bcast_req_t        req,
    output logic              legal,
    output logic [LANE_W-1:0] lane
);

    logic [SCL_W-1:0]  scaled;
    logic [LANE_W-1:0] wide;

    always_comb begin
        scaled = scale_imm(req.imm, req.shift);
        wide   = {{(LANE_W-SCL_W){scaled[SCL_W-1]}}, scaled};
        legal  = !(req.size == ESZ_8 && req.shift);
        unique case (req.size)
            ESZ_8:   lane = {8{wide[7:0]}};
            ESZ_16:  lane = {4{wide[15:0]}};
            ESZ_32:  lane = {2{wide[31:0]}};
            default: lane = wide;
        endcase
    end

    // R5: the top and bottom bytes of a 64-bit lane match for 8-bit elements
    always_comb begin
        if (req.size == ESZ_8)
            assert_byte_repl_R5: assert (lane[63:56] == lane[7:0]);
    end

endmodule

// File: rtl/vbc_replicate.sv
module vbc_replicate
    import vbc_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic [LANE_W-1:0] lane,
    output logic [VLEN-1:0]   vec
);

    localparam int LANES = VLEN / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign vec[g*LANE_W +: LANE_W] = lane;
    end

endmodule

// File: rtl/vimm_bcast.sv
module vimm_bcast
    import vbc_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_size,
    input  logic             in_shift,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [REG_W-1:0] in_dst,
    output logic [VLEN-1:0]  out_data,
    output logic             out_we,
    output logic [REG_W-1:0] out_dst,
    output logic             out_illegal
);

    bcast_req_t        req;
    logic              legal;
    logic [LANE_W-1:0] lane;
    logic [VLEN-1:0]   vec;

    assign req.size  = esize_e'(in_size);
    assign req.shift = in_shift;
    assign req.imm   = in_imm;

    vbc_decode u_dec (
        .req   (req),
        .legal (legal),
        .lane  (lane)
    );

    vbc_replicate #(.VLEN(VLEN)) u_rep (
        .lane (lane),
        .vec  (vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_we      <= 1'b0;
            out_illegal <= 1'b0;
            out_data    <= '0;
            out_dst     <= '0;
        end else begin
            out_we      <= in_valid && legal;
            out_illegal <= in_valid && !legal;
            if (in_valid) begin
                out_data <= legal ? vec : '0;
                out_dst  <= in_dst;
            end
        end
    end

    assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(out_we && out_illegal));

    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_data == '0));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_we || out_illegal));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_we && !out_illegal));

    assert_repl_R5: assert property (@(posedge clk) disable iff (rst)
        out_we |-> (out_data[VLEN-1 -: LANE_W] == out_data[LANE_W-1:0]));

    assert_dst_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dst == $past(in_dst)));

endmodule

// File: tb/vimm_bcast_test.sv
module vimm_bcast_test;

    localparam int VLEN   = 256;
    localparam int CLK_NS = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [1:0]      in_size = '0;
    logic            in_shift = 1'b0;
    logic [7:0]      in_imm = '0;
    logic [4:0]      in_dst = '0;
    logic [VLEN-1:0] out_data;
    logic            out_we;
    logic [4:0]      out_dst;
    logic            out_illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    vimm_bcast #(.VLEN(VLEN)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_shift(in_shift), .in_imm(in_imm), .in_dst(in_dst),
        .out_data(out_data), .out_we(out_we), .out_dst(out_dst),
        .out_illegal(out_illegal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] expect_vec(input logic [1:0] sz,
                                                   input logic sh, input logic [7:0] imm);
        longint     v;
        logic [63:0] bits;
        int          w;
        logic [VLEN-1:0] r;
        v    = longint'($signed(imm));
        if (sh) v = v * 256;
        bits = 64'(v);
        w    = 8 << sz;
        for (int b = 0; b < VLEN; b++) r[b] = bits[b % w];
        return r;
    endfunction

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_we == 1'b0 && out_illegal == 1'b0, "R9", "flags in reset",
            {out_we, out_illegal}, '0);
        chk(out_data == '0 && out_dst == '0, "R9", "data in reset", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_we && !out_illegal, "R6", "idle after reset", {out_we, out_illegal}, '0);

        for (int sz = 0; sz < 4; sz++) begin
            for (int sh = 0; sh < 2; sh++) begin
                for (int im = 0; im < 256; im++) begin
                    logic [4:0]      d;
                    bit              bad;
                    logic [VLEN-1:0] e;
                    d   = 5'(im + sz * 7 + sh * 13);
                    bad = (sz == 0) && (sh == 1);
                    e   = bad ? '0 : expect_vec(2'(sz), 1'(sh), 8'(im));
                    in_valid = 1'b1; in_size = 2'(sz); in_shift = 1'(sh);
                    in_imm = 8'(im); in_dst = d;
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_imm   = ~in_imm;
                    in_dst   = ~d;
                    if (bad) begin
                        chk(out_illegal && !out_we, "R4", "illegal flag/we",
                            {out_illegal, out_we}, 2'b10);
                        chk(out_data == '0, "R8", "illegal data", out_data, '0);
                    end else begin
                        chk(out_we && !out_illegal, "R6", "write pulse",
                            {out_we, out_illegal}, 2'b10);
                        // R1 R2 R3 R5: element width, sign, shift, replication
                        chk(out_data == e, sh ? "R3" : (im > 127 ? "R2" : "R5"),
                            "data", out_data, e);
                        if (sz == 3 && im == 255 && sh == 0)
                            chk(out_data[63:0] == 64'hFFFF_FFFF_FFFF_FFFF, "R1",
                                "64-bit minus one", out_data, e);
                    end
                    chk(out_dst == d, "R7", "dst", VLEN'(out_dst), VLEN'(d));
                    @(negedge clk);
                    chk(!out_we && !out_illegal, "R6", "no lingering pulse",
                        {out_we, out_illegal}, '0);
                    chk(out_dst == d, "R7", "dst held while idle",
                        VLEN'(out_dst), VLEN'(d));
                end
            end
        end

        // R6: back-to-back legal requests give one pulse per cycle
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1; in_size = 2'b01; in_shift = 1'b1;
            in_imm = 8'(k + 1); in_dst = 5'(k);
            @(negedge clk);
            chk(out_we && out_data == expect_vec(2'b01, 1'b1, 8'(k + 1)), "R6",
                "back-to-back", out_data, expect_vec(2'b01, 1'b1, 8'(k + 1)));
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R9: reset after activity clears everything
        in_valid = 1'b1; in_size = 2'b11; in_shift = 1'b0; in_imm = 8'h80; in_dst = 5'd9;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(!out_we && !out_illegal && out_data == '0 && out_dst == '0, "R9",
            "reset after use", out_data, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule